// File: doc/BRIEF.md
# Mixed-Sign Integer Multiplier Unit

This unit multiplies two 16-bit integers in one clock cycle. Every product comes from a single 17-by-17 signed multiply array. Each operand gets one extra top bit before it enters the array. The bit is a copy of the operand's MSB when that operand is marked signed, and zero when it is marked unsigned. With that one change, the same signed array gives exact unsigned, signed and mixed-sign products.

The two sign flags are independent, one per operand. Setting the first operand signed and the second unsigned gives the mixed mode. A size select switches to byte mode. In byte mode only the low byte of each operand is used, and the 16-bit result lands in the low half of the output.

A start strobe loads the operands and modes. On the next clock the registered product appears together with a one-cycle done pulse. A small controller with two states sequences this:
- `ST_IDLE`: no fresh result is shown.
- `ST_SHOW`: the result captured on the previous edge is shown and done is high.

The controller has three transitions:
- `ST_IDLE -> ST_SHOW` on start (named *launch*).
- `ST_SHOW -> ST_SHOW` on start (named *chain*, back-to-back issue).
- `ST_SHOW -> ST_IDLE` when start is low (named *retire*).

Top module: `mixmul_unit`

## Requirements
- R1: After reset, `done` is 0 and `product` is all zeros.
- R2: `done` is 1 in exactly the cycle after each cycle with `start` high. Otherwise it is 0.
- R3: With both sign flags 0 and `size_byte` 0, `product` equals the unsigned 32-bit product of `a_in` and `b_in`.
- R4: With both sign flags 1 and `size_byte` 0, `product` equals the two's complement 32-bit product of the signed operands.
- R5: With exactly one sign flag set, the flagged operand is treated as signed and the other as unsigned. `product` is the exact two's complement 32-bit product. The mixed mode is `a_signed`=1, `b_signed`=0.
- R6: With `size_byte` 1, only bits [7:0] of each operand are used. Bits [15:8] have no effect on `product`.
- R7: With `size_byte` 1, `product[15:0]` holds the 16-bit product of the bytes, extended per their sign flags. `product[31:16]` is 0.
- R8: `product` keeps its value in every cycle that follows a cycle with `start` low.
- R9: Starts in consecutive cycles yield each operation's result in consecutive cycles, with `done` held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture operands and modes this cycle |
| size_byte | input | 1 | 1: 8-by-8 multiply on the low bytes; 0: 16-by-16 |
| a_signed | input | 1 | 1: operand A is two's complement |
| b_signed | input | 1 | 1: operand B is two's complement |
| a_in | input | 16 | Operand A |
| b_in | input | 16 | Operand B |
| product | output | 32 | Registered result |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
Two things can fall in the same cycle: the unit is presenting one result with done high, and a new start arrives that must replace that result on the next edge. The bench provokes this with runs of back-to-back starts that cycle through the sign and size modes. It checks each cycle's product against a reference computed separately, and confirms that done never drops inside the run. It also checks that done falls, and the product holds, on the first idle cycle after the run.

// File: rtl/mixmul_pkg.sv
package mixmul_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } mixmul_state_e;
endpackage

// File: rtl/mixmul_extend.sv
module mixmul_extend #(
    parameter int W = 16
) (
    input  logic [W-1:0] op,
    input  logic         is_signed,
    input  logic         byte_mode,
    output logic [W:0]   ext
);
    localparam int HW = W / 2;

    always_comb begin
        if (byte_mode)
            ext = {{(W + 1 - HW){is_signed & op[HW-1]}}, op[HW-1:0]};
        else
            ext = {is_signed & op[W-1], op};
    end
endmodule

// File: rtl/mixmul_core.sv
module mixmul_core #(
    parameter int CW = 17
) (
    input  logic signed [CW-1:0]   a,
    input  logic signed [CW-1:0]   b,
    output logic signed [2*CW-1:0] p
);
    always_comb begin
        p = a * b;
    end

    // R5
    always_comb begin
        if (!$isunknown(p))
            width_fit_chk: assert (p[2*CW-1] == p[2*CW-2])
                else $error("product escapes the 33-bit range");
    end
endmodule

// File: rtl/mixmul_ctrl.sv
module mixmul_ctrl
    import mixmul_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic done
);
    mixmul_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_SHOW;
            ST_SHOW: if (!start) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        load = start;
        done = (state_q == ST_SHOW);
    end

    // R2
    done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);
endmodule

// File: rtl/mixmul_unit.sv
module mixmul_unit #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           size_byte,
    input  logic           a_signed,
    input  logic           b_signed,
    input  logic [W-1:0]   a_in,
    input  logic [W-1:0]   b_in,
    output logic [2*W-1:0] product,
    output logic           done
);
    localparam int CW = W + 1;
    localparam int PW = 2 * W;

    logic [W-1:0]   ops  [2];
    logic           sgns [2];
    logic [CW-1:0]  exts [2];
    logic [2*CW-1:0] full;
    logic [PW-1:0]  result;
    logic           load;

    assign ops[0]  = a_in;
    assign ops[1]  = b_in;
    assign sgns[0] = a_signed;
    assign sgns[1] = b_signed;

    for (genvar g = 0; g < 2; g++) begin : g_ext
        mixmul_extend #(.W(W)) u_ext (
            .op       (ops[g]),
            .is_signed(sgns[g]),
            .byte_mode(size_byte),
            .ext      (exts[g])
        );
    end

    mixmul_core #(.CW(CW)) u_core (
        .a(exts[0]),
        .b(exts[1]),
        .p(full)
    );

    mixmul_ctrl u_ctrl (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .load (load),
        .done (done)
    );

    always_comb begin
        if (size_byte) result = {{W{1'b0}}, full[W-1:0]};
        else           result = full[PW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    product <= '0;
        else if (load) product <= result;
    end

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(product));
    // R7
    byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && size_byte) |=> (product[PW-1:W] == '0));
endmodule

// File: tb/mixmul_unit_test.sv
module mixmul_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        size_byte = 1'b0;
    logic        a_signed = 1'b0;
    logic        b_signed = 1'b0;
    logic [15:0] a_in = '0;
    logic [15:0] b_in = '0;
    logic [31:0] product;
    logic        done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mixmul_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .size_byte(size_byte),
        .a_signed(a_signed), .b_signed(b_signed), .a_in(a_in), .b_in(b_in),
        .product(product), .done(done)
    );

    function automatic logic [31:0] ref_mul(logic [15:0] a, logic [15:0] b,
                                            bit sa, bit sb, bit byt);
        longint ea, eb, p;
        if (byt) begin
            ea = sa ? longint'($signed(a[7:0])) : longint'(a[7:0]);
            eb = sb ? longint'($signed(b[7:0])) : longint'(b[7:0]);
            p  = ea * eb;
            return {16'h0, p[15:0]};
        end
        ea = sa ? longint'($signed(a)) : longint'(a);
        eb = sb ? longint'($signed(b)) : longint'(b);
        p  = ea * eb;
        return p[31:0];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(logic [15:0] a, logic [15:0] b, bit sa, bit sb, bit byt);
        a_in = a; b_in = b; a_signed = sa; b_signed = sb; size_byte = byt;
        start = 1'b1;
    endtask

    task automatic one(string req, logic [15:0] a, logic [15:0] b,
                       bit sa, bit sb, bit byt);
        @(negedge clk);
        drive(a, b, sa, sb, byt);
        @(negedge clk);
        start = 1'b0;
        check(req, product, ref_mul(a, b, sa, sb, byt));
        check("R2 done", {31'b0, done}, 32'd1);
        @(negedge clk);
        check("R2 done low", {31'b0, done}, 32'd0);
        check("R8 hold", product, ref_mul(a, b, sa, sb, byt));
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] prev;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1
        check("R1 product", product, 32'h0);
        check("R1 done", {31'b0, done}, 32'd0);
        rst_n = 1'b1;

        // directed corners
        one("R3", 16'hFFFF, 16'hFFFF, 0, 0, 0);
        one("R4", 16'h8000, 16'h8000, 1, 1, 0);
        one("R4", 16'hFFFF, 16'h7FFF, 1, 1, 0);
        one("R5", 16'h8000, 16'hFFFF, 1, 0, 0);
        one("R5", 16'hFFFF, 16'hFFFF, 0, 1, 0);
        one("R7", 16'h0080, 16'h0080, 1, 1, 1);
        one("R7", 16'h00FF, 16'h00FF, 0, 0, 1);
        one("R7", 16'h00FF, 16'h00FF, 1, 0, 1);
        // R6: upper bytes must not matter
        one("R6", 16'hA5FE, 16'h5A03, 1, 1, 1);
        check("R6 same as clean", product, ref_mul(16'h00FE, 16'h0003, 1, 1, 1));

        // R9: back-to-back across modes
        for (int k = 0; k < 8; k++) begin
            logic [15:0] a, b;
            bit sa, sb, byt;
            a = 16'($urandom); b = 16'($urandom);
            sa = k[0]; sb = k[1]; byt = k[2];
            @(negedge clk);
            if (k > 0) begin
                check("R9 product", product, prev);
                check("R9 done", {31'b0, done}, 32'd1);
            end
            drive(a, b, sa, sb, byt);
            prev = ref_mul(a, b, sa, sb, byt);
        end
        @(negedge clk);
        start = 1'b0;
        check("R9 last", product, prev);
        @(negedge clk);
        check("R2 retire", {31'b0, done}, 32'd0);
        check("R8 idle hold", product, prev);

        // random
        for (int i = 0; i < 200; i++) begin
            logic [2:0] m;
            m = 3'($urandom);
            one(m[2] ? "R6 R7 random" : (m[0] ^ m[1]) ? "R5 random" :
                m[0] ? "R4 random" : "R3 random",
                16'($urandom), 16'($urandom), m[0], m[1], m[2]);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule